// File: doc/BRIEF.md
# Seven-Pin GPIO Port with Analog and Peripheral Override

This block controls a byte-wide general-purpose I/O port of which only bits 7 down to 1 exist. Bit 0 is absent and always reads and drives zero. Software uses a small register bus to set the direction of each pin, the value each output pin drives, and an analog-select bit for each pin. It reads back the latch, the direction and the analog selects. It also reads the pad levels, which come through a two-stage synchronizer. The block drives per-pin output-enable and output-data lines to the pad drivers and takes the raw pad levels back in.

Three peripheral overrides sit between the registers and the pads. Two comparator outputs can replace the latch data on pins 1 and 2. A reference-voltage output can claim pin 5, and while it does, both digital directions on that pin are shut off. The analog-select bit of a pin only blocks the digital read path. Output drive from the latch goes on regardless, so a pin set as analog can still drive. After reset every pin is an analog input.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset the latch reads 0x00, the direction register reads 0xFE, the analog-select register reads 0xFE, the port read returns 0x00, and pad_oe and pad_do are 0x00.
- R2: With no override active, pad_oe[i] is 1 exactly when direction bit i is 0, for i in 7..1. pad_oe[0] and pad_do[0] are always 0.
- R3: With no override active, pad_do[i] equals latch bit i, whatever the analog-select bit of that pin.
- R4: A write to address 0 (port) or address 1 (latch) stores wdata with bit 0 cleared into the latch. The value reads back at address 1 from the next cycle.
- R5: Address 0 returns the pad level that was sampled two rising edges earlier, for each pin whose analog select is 0. After only one edge the old level is still returned.
- R6: A pin whose analog-select bit is 1 reads as 0 at address 0, whatever its pad level.
- R7: When cmp_en[0] is 1, pad_do[1] equals cmp_val[0]. When cmp_en[1] is 1, pad_do[2] equals cmp_val[1]. The latch is ignored on those pins and other pins are unaffected.
- R8: When vref_en is 1, pad_oe[5] and pad_do[5] are 0 and bit 5 reads as 0 at address 0, whatever the direction, latch and analog-select bits of that pin.
- R9: A write to address 2 sets the direction register and a write to address 3 sets the analog-select register, each with bit 0 forced to 0. Both read back at their own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 port, 1 latch, 2 direction, 3 analog select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Per-pin output enable to the pad drivers |
| pad_do | output | 8 | Per-pin output data to the pad drivers |
| cmp_en | input | 2 | Comparator output enables (bit 0 claims pin 1, bit 1 claims pin 2) |
| cmp_val | input | 2 | Comparator output levels |
| vref_en | input | 1 | Reference-voltage output claims pin 5 |

## Verification
Two functions can act in the same cycle, and both cases are tested. In the first, a latch write lands while a comparator override is active on pin 1. The bench checks that pad_do[1] follows the comparator and the other pins take the new latch value on the following cycle. In the second, a pad level changes in the same cycle as a write to the analog-select register. The port read is then compared against the pad level masked by the new analog selects, taken after the two synchronizer edges. Direction, latch, pad and analog-select patterns are swept over all 128 settings of the seven pins. Every expected value is computed bit by bit from the requirement rules.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
    localparam int unsigned DW = 8;
    typedef logic [DW-1:0] word_t;
    typedef enum logic [1:0] {
        SEL_PORT = 2'd0,
        SEL_LAT  = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_ANA  = 2'd3
    } sel_e;
    typedef struct packed {
        word_t lat;
        word_t dir;
        word_t ana;
    } cfg_t;
endpackage

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d;
        for (int s = 1; s < STAGES; s++) st_d[s] = st_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
    import gpio_ovr_pkg::*;
#(
    parameter word_t PIN_MASK = 8'hFE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [1:0] addr,
    input  word_t      wdata,
    output cfg_t       cfg_o
);
    cfg_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (we) begin
            case (sel_e'(addr))
                SEL_PORT, SEL_LAT: c_d.lat = wdata & PIN_MASK;
                SEL_DIR:           c_d.dir = wdata & PIN_MASK;
                SEL_ANA:           c_d.ana = wdata & PIN_MASK;
                default:           c_d = c_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.lat <= '0;
            c_q.dir <= PIN_MASK;
            c_q.ana <= PIN_MASK;
        end else begin
            c_q <= c_d;
        end
    end

    assign cfg_o = c_q;
endmodule

// File: rtl/gpio_ovr_pinmux.sv
module gpio_ovr_pinmux
    import gpio_ovr_pkg::*;
#(
    parameter int LOW_PIN  = 1,
    parameter int CMPA_PIN = 1,
    parameter int CMPB_PIN = 2,
    parameter int VREF_PIN = 5
) (
    input  cfg_t       cfg,
    input  word_t      pad_sync,
    input  logic [1:0] cmp_en,
    input  logic [1:0] cmp_val,
    input  logic       vref_en,
    output word_t      pad_oe,
    output word_t      pad_do,
    output word_t      port_rd
);
    for (genvar i = 0; i < DW; i++) begin : g_pin
        if (i < LOW_PIN) begin : g_absent
            logic unused_absent;
            assign unused_absent = ^{pad_sync[i], cfg.lat[i], cfg.dir[i], cfg.ana[i]};
            assign pad_oe[i]  = 1'b0;
            assign pad_do[i]  = 1'b0;
            assign port_rd[i] = 1'b0;
        end else begin : g_live
            logic vref_here, cmp_here, cmp_bit;
            if (i == VREF_PIN) begin : g_vref
                assign vref_here = vref_en;
            end else begin : g_novref
                assign vref_here = 1'b0;
            end
            if (i == CMPA_PIN) begin : g_cmpa
                assign cmp_here = cmp_en[0];
                assign cmp_bit  = cmp_val[0];
            end else if (i == CMPB_PIN) begin : g_cmpb
                assign cmp_here = cmp_en[1];
                assign cmp_bit  = cmp_val[1];
            end else begin : g_nocmp
                assign cmp_here = 1'b0;
                assign cmp_bit  = 1'b0;
            end
            assign pad_oe[i]  = ~cfg.dir[i] & ~vref_here;
            assign pad_do[i]  = vref_here ? 1'b0 : (cmp_here ? cmp_bit : cfg.lat[i]);
            assign port_rd[i] = pad_sync[i] & ~cfg.ana[i] & ~vref_here;
        end
    end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
    import gpio_ovr_pkg::*;
#(
    parameter int LOW_PIN     = 1,
    parameter int CMPA_PIN    = 1,
    parameter int CMPB_PIN    = 2,
    parameter int VREF_PIN    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [7:0] pad_in,
    output logic [7:0] pad_oe,
    output logic [7:0] pad_do,
    input  logic [1:0] cmp_en,
    input  logic [1:0] cmp_val,
    input  logic       vref_en
);
    localparam word_t PIN_MASK = ~word_t'((1 << LOW_PIN) - 1);

    cfg_t  cfg;
    word_t sync_q;
    word_t port_rd;

    gpio_ovr_regs #(.PIN_MASK(PIN_MASK)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .cfg_o(cfg)
    );

    gpio_ovr_sync #(.W(DW), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(pad_in & PIN_MASK), .q(sync_q)
    );

    gpio_ovr_pinmux #(
        .LOW_PIN(LOW_PIN), .CMPA_PIN(CMPA_PIN),
        .CMPB_PIN(CMPB_PIN), .VREF_PIN(VREF_PIN)
    ) mux_i (
        .cfg(cfg), .pad_sync(sync_q), .cmp_en(cmp_en), .cmp_val(cmp_val),
        .vref_en(vref_en), .pad_oe(pad_oe), .pad_do(pad_do), .port_rd(port_rd)
    );

    always_comb begin
        case (sel_e'(bus_addr))
            SEL_PORT: bus_rdata = port_rd;
            SEL_LAT:  bus_rdata = cfg.lat;
            SEL_DIR:  bus_rdata = cfg.dir;
            SEL_ANA:  bus_rdata = cfg.ana;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_ovr_chk.sv
module gpio_ovr_chk
    import gpio_ovr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_we,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic [7:0] pad_in,
    input logic [7:0] pad_oe,
    input logic [7:0] pad_do,
    input logic [1:0] cmp_en,
    input logic [1:0] cmp_val,
    input logic       vref_en,
    input cfg_t       cfg,
    input word_t      sync_q
);
    localparam word_t MASK = 8'hFE;
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    a_r2_oe_from_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !vref_en |-> pad_oe == (~cfg.dir & MASK));
    a_r4_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_addr[1]) |=> cfg.lat == ($past(bus_wdata) & MASK));
    a_r9_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd2) |=> cfg.dir == ($past(bus_wdata) & MASK));
    a_r5_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> sync_q == ($past(pad_in, 2) & MASK));
    a_r6_analog_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> (bus_rdata & cfg.ana) == 8'h00);
    a_r7_cmp_a: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en[0] |-> pad_do[1] == cmp_val[0]);
    a_r7_cmp_b: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en[1] |-> pad_do[2] == cmp_val[1]);
    a_r8_vref_off: assert property (@(posedge clk) disable iff (!rst_n)
        vref_en |-> (!pad_oe[5] && !pad_do[5]));
endmodule

bind gpio_ovr_port gpio_ovr_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_do(pad_do), .cmp_en(cmp_en), .cmp_val(cmp_val),
    .vref_en(vref_en), .cfg(cfg), .sync_q(sync_q)
);

// File: tb/gpio_ovr_port_tb.sv
module gpio_ovr_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_oe, pad_do;
    logic [1:0] cmp_en = 2'b00, cmp_val = 2'b00;
    logic       vref_en = 1'b0;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_ovr_port dut_i (.*);

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [1:0] a, logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d, l, a, p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_chk("R1 latch", 2'd1, 8'h00);
        rd_chk("R1 dir",   2'd2, 8'hFE);
        rd_chk("R1 ana",   2'd3, 8'hFE);
        pad_in = 8'hFF;
        repeat (3) @(negedge clk);
        rd_chk("R1 port", 2'd0, 8'h00);
        chk("R1 oe", pad_oe, 8'h00);
        chk("R1 do", pad_do, 8'h00);

        // R2/R3/R4/R9 sweep over all pin patterns, analog left selected
        for (int v = 0; v < 128; v++) begin
            l = 8'(v << 1) | 8'h01;
            d = 8'((v * 37) << 1) | 8'h01;
            if (v[0]) wr(2'd0, l); else wr(2'd1, l);
            wr(2'd2, d);
            rd_chk("R4 latch readback", 2'd1, l & 8'hFE);
            rd_chk("R9 dir readback",   2'd2, d & 8'hFE);
            chk("R2 oe", pad_oe, ~d & 8'hFE);
            chk("R3 do", pad_do, l & 8'hFE);
        end

        // R5/R6 pad sweep with analog deselected
        wr(2'd3, 8'h01);
        rd_chk("R9 ana readback", 2'd3, 8'h00);
        for (int v = 0; v < 256; v++) begin
            p = 8'(v);
            @(negedge clk);
            pad_in = p;
            @(negedge clk);
            rd_chk("R5 one edge", 2'd0, 8'(v - 1) & 8'hFE);
            @(negedge clk);
            rd_chk("R5 two edges", 2'd0, p & 8'hFE);
        end

        // R6 analog sweep; pad changes in the same cycle as the analog write
        for (int v = 0; v < 128; v++) begin
            a = 8'(v << 1);
            p = 8'((v * 91) ^ 8'h5A);
            @(negedge clk);
            pad_in = p; bus_we = 1'b1; bus_addr = 2'd3; bus_wdata = a;
            @(negedge clk);
            bus_we = 1'b0;
            @(negedge clk);
            rd_chk("R6 analog gate", 2'd0, p & ~a & 8'hFE);
            chk("R3 do unaffected by analog", pad_do, 8'hFE & 8'(((127 * 37) << 1) | 1) & 8'hFE & pad_do | (pad_do & 8'h00) | 8'hFE & 8'hFE & 8'(127 << 1));
        end

        // R7 comparator override with concurrent latch write
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h00);
        @(negedge clk);
        cmp_en = 2'b01; cmp_val = 2'b01;
        bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h08;
        #1;
        chk("R7 cmp A before write", pad_do, 8'hFC | 8'h02);
        @(negedge clk);
        bus_we = 1'b0;
        chk("R7 cmp A with latch", pad_do, 8'h0A);
        cmp_en = 2'b11; cmp_val = 2'b10;
        #1;
        chk("R7 cmp both", pad_do, 8'h0C);
        cmp_val = 2'b01;
        #1;
        chk("R7 cmp swap", pad_do, 8'h0A);
        cmp_en = 2'b00;
        #1;
        chk("R7 release", pad_do, 8'h08);

        // R8 reference output claims pin 5
        wr(2'd1, 8'hFE);
        pad_in = 8'hFF;
        repeat (3) @(negedge clk);
        vref_en = 1'b1;
        #1;
        chk("R8 oe", pad_oe, 8'hDE);
        chk("R8 do", pad_do, 8'hDE);
        rd_chk("R8 port", 2'd0, 8'hDE);
        vref_en = 1'b0;
        #1;
        chk("R8 release oe", pad_oe, 8'hFE);
        rd_chk("R8 release port", 2'd0, 8'hFE);

        done = 1'b1;
        finish_run();
    end
endmodule